// File: doc/BRIEF.md
# NAND Flash Bus Phase Sequencer

This block sits between a host register port and the pins of a NAND flash device. The host runs one bus phase at a time. It loads a command byte or an address byte into a holding register, then writes a single start bit into the control register. The sequencer asserts chip enable, runs the phase on the pins, and raises a done flag that the host polls before it starts the next phase. The host builds full device operations (read, program, erase, ID and status queries) as a string of such phases.

Page data moves through an internal buffer. The buffer has a main area followed by a spare area, and the host reads and writes it one halfword at a time. A data-input phase moves the buffer onto the bus. A data-output phase fills the buffer from the device. Data output has three variants: a full page, a short device-ID read, or a single status read. The host interprets the status byte itself: bit 0 set means the last program or erase failed, and bit 7 clear means the device is write-protected. The block has no ECC logic. An external ECC result comes in on a 4-bit input, and the host reads it back next to the done flag: bits 3:2 hold the main-area result and bits 1:0 hold the spare-area result.

Top module: `nand_op_seq`

## Requirements
- R1: A command phase (control write 0x0001) gives exactly one write cycle with CLE high and ALE low. During that cycle the data bus carries the full 16-bit value held in the command register (register 0).
- R2: An address phase (control write 0x0002) gives exactly one write cycle with ALE high and CLE low. During that cycle the data bus carries the value held in the address register (register 1).
- R3: Reading register 2 returns the done flag in bit 15. Done reads 1 after reset, reads 0 starting in the cycle after an accepted start, and returns to 1 when the phase ends. CE# is low exactly while a phase is pending or running.
- R4: A start write is ignored when its low four bits are not one-hot, when it selects data output with type 3, or when it arrives while a phase is running. Writes to the command, address and configuration registers are also ignored while a phase is running.
- R5: A data-input phase (0x0004) in 8-bit mode first writes every byte of the main area, then every byte of the spare area, as one write cycle per byte. Inside each buffer halfword the low byte goes out first, and the upper data lines are driven to 0.
- R6: In 16-bit mode (configuration bit 0 set) every write or read cycle carries one whole halfword. A data-input phase therefore takes half as many cycles as in 8-bit mode.
- R7: A page read (0x0008, type bits 5:4 = 0) does not drive RE# until R/B# is high. It then fills the main area followed by the spare area, using the same byte order as R5. The spare area is page size divided by 32 bytes and begins at halfword BUF_BYTES/2.
- R8: An ID read (type 1, control 0x0018) does ID_UNITS read cycles. A status read (type 2, control 0x0028) does one read cycle. Both place their data from the start of the main buffer and leave the rest of the buffer unchanged.
- R9: Every WE# or RE# pulse stays low for T cycles and then high for T cycles. T is configuration bits 7:4, and any value below 2 is treated as 2.
- R10: Configuration bit 1 selects a 2048-byte page and is cleared to 0 when BUF_BYTES is below 2048. After reset, reading register 3 returns 0x0020 (8-bit bus, 512-byte page, T = 2).
- R11: Bits 3:0 of register 2 read back the ecc_status input as it is in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 address, 2 control/status, 3 configuration |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for the register selected by reg_addr |
| buf_we | input | 1 | Host buffer write strobe |
| buf_addr | input | 10 | Buffer halfword address (main area first, then spare) |
| buf_wdata | input | 16 | Buffer write data |
| buf_rdata | output | 16 | Buffer read data, combinational |
| ecc_status | input | 4 | External ECC result: main area in 3:2, spare area in 1:0 |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb_n | input | 1 | Ready/busy from the device, high when ready |
| nand_dq_o | output | 16 | Data driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 16 | Data from the device |

## Verification
A wrong unit index or a stale spare-area flag shows up on the pins within one strobe period. The bytes come out in the wrong order, or the phase runs one cycle too many or too few. The bench therefore logs every WE# pulse and compares whole streams against a model of the buffer layout. A done flag that is stuck, or a start that is accepted while the block is busy, shows at the very next poll of register 2, or as an extra CLE cycle in the logged stream. Capture errors on the read side leave wrong bytes in the buffer, and host readback finds them after the phase.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RDY  = 2'd1,
        ST_XFER = 2'd2
    } seq_st_e;

    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADR  = 3'd1,
        OP_DIN  = 3'd2,
        OP_PAGE = 3'd3,
        OP_ID   = 3'd4,
        OP_STAT = 3'd5
    } op_e;

    localparam logic [1:0] RA_CMD = 2'd0;
    localparam logic [1:0] RA_ADR = 2'd1;
    localparam logic [1:0] RA_CTL = 2'd2;
    localparam logic [1:0] RA_CFG = 2'd3;

    function automatic logic op_drives(op_e o);
        return (o == OP_CMD) || (o == OP_ADR) || (o == OP_DIN);
    endfunction

    function automatic logic op_reads(op_e o);
        return (o == OP_PAGE) || (o == OP_ID) || (o == OP_STAT);
    endfunction

endpackage

// File: rtl/nand_seq_pulse.sv
module nand_seq_pulse #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] len,
    output logic          low,
    output logic          sample,
    output logic          last
);
    typedef enum logic [1:0] {P_OFF, P_LO, P_HI} ph_e;
    typedef struct packed {
        ph_e           ph;
        logic [TW-1:0] cnt;
    } pulse_t;

    pulse_t pl_d, pl_q;

    assign low    = (pl_q.ph == P_LO);
    assign sample = (pl_q.ph == P_LO) && (pl_q.cnt == '0);
    assign last   = (pl_q.ph == P_HI) && (pl_q.cnt == '0);

    always_comb begin
        pl_d = pl_q;
        case (pl_q.ph)
            P_OFF: begin
                if (start) begin
                    pl_d.ph  = P_LO;
                    pl_d.cnt = len - TW'(1);
                end
            end
            P_LO: begin
                if (pl_q.cnt == '0) begin
                    pl_d.ph  = P_HI;
                    pl_d.cnt = len - TW'(1);
                end else begin
                    pl_d.cnt = pl_q.cnt - TW'(1);
                end
            end
            P_HI: begin
                if (pl_q.cnt == '0) begin
                    pl_d.ph  = start ? P_LO : P_OFF;
                    pl_d.cnt = len - TW'(1);
                end else begin
                    pl_d.cnt = pl_q.cnt - TW'(1);
                end
            end
            default: pl_d.ph = P_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_q <= '{ph: P_OFF, cnt: '0};
        end else begin
            pl_q <= pl_d;
        end
    end
endmodule

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
    parameter int DEPTH = 528,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [15:0]   h_wdata,
    output logic [15:0]   h_rdata,
    input  logic          s_we,
    input  logic [1:0]    s_mask,
    input  logic [AW-1:0] s_addr,
    input  logic [15:0]   s_wdata,
    output logic [15:0]   s_rdata
);
    logic [15:0] mem [DEPTH];
    logic        h_ok;

    assign h_ok    = ({1'b0, h_addr} < (AW+1)'(DEPTH));
    assign h_rdata = h_ok ? mem[h_addr] : '0;
    assign s_rdata = mem[s_addr];

    always_ff @(posedge clk) begin
        if (h_we && h_ok) begin
            mem[h_addr] <= h_wdata;
        end
        if (s_we) begin
            if (s_mask[0]) mem[s_addr][7:0]  <= s_wdata[7:0];
            if (s_mask[1]) mem[s_addr][15:8] <= s_wdata[15:8];
        end
    end
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int BUF_BYTES = 1024,
    parameter int ID_UNITS  = 4,
    parameter int TW        = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        buf_we,
    input  logic [$clog2(BUF_BYTES/2 + BUF_BYTES/64)-1:0] buf_addr,
    input  logic [15:0] buf_wdata,
    output logic [15:0] buf_rdata,
    input  logic [3:0]  ecc_status,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    input  logic        nand_rb_n,
    output logic [15:0] nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [15:0] nand_dq_i
);
    localparam int MAIN_HW = BUF_BYTES / 2;
    localparam int DEPTH   = MAIN_HW + BUF_BYTES / 64;
    localparam int AW      = $clog2(DEPTH);
    localparam int CW      = 13;
    localparam bit BIG_OK  = (BUF_BYTES >= 2048);

    typedef struct packed {
        seq_st_e       st;
        op_e           op;
        logic          spare;
        logic [CW-1:0] idx;
        logic          done;
        logic [15:0]   cmd;
        logic [15:0]   adr;
        logic          wide;
        logic          page2k;
        logic [TW-1:0] tlen;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          tm_start, tm_low, tm_sample, tm_last;
    logic [TW-1:0] tlen_eff;
    logic [CW-1:0] page_bytes, main_units, spare_units, cur_len, unit_hw;
    logic [AW-1:0] s_addr;
    logic          lane, s_we;
    logic [1:0]    s_mask;
    logic [15:0]   s_rdata, s_wdata;
    logic          idle, wr_ok, trig_ok;
    logic [3:0]    trig;
    op_e           trig_op;

    assign tlen_eff    = (seq_q.tlen < TW'(2)) ? TW'(2) : seq_q.tlen;
    assign page_bytes  = seq_q.page2k ? CW'(2048) : CW'(512);
    assign main_units  = page_bytes >> seq_q.wide;
    assign spare_units = page_bytes >> (5 + int'(seq_q.wide));

    // unit index to buffer halfword and byte lane
    assign unit_hw = seq_q.wide ? seq_q.idx : (seq_q.idx >> 1);
    assign lane    = seq_q.idx[0] & ~seq_q.wide;
    assign s_addr  = AW'(unit_hw + (seq_q.spare ? CW'(MAIN_HW) : CW'(0)));
    assign s_mask  = seq_q.wide ? 2'b11 : (lane ? 2'b10 : 2'b01);
    assign s_wdata = seq_q.wide ? nand_dq_i : {nand_dq_i[7:0], nand_dq_i[7:0]};

    always_comb begin
        case (seq_q.op)
            OP_DIN, OP_PAGE: cur_len = seq_q.spare ? spare_units : main_units;
            OP_ID:           cur_len = CW'(ID_UNITS);
            default:         cur_len = CW'(1);
        endcase
    end

    // start decode: exactly one bit of [3:0]; output type 3 is rejected
    assign idle  = (seq_q.st == ST_IDLE);
    assign wr_ok = reg_we && idle;
    assign trig  = reg_wdata[3:0];
    always_comb begin
        trig_op = OP_CMD;
        trig_ok = 1'b1;
        case (trig)
            4'b0001: trig_op = OP_CMD;
            4'b0010: trig_op = OP_ADR;
            4'b0100: trig_op = OP_DIN;
            4'b1000: begin
                case (reg_wdata[5:4])
                    2'd0:    trig_op = OP_PAGE;
                    2'd1:    trig_op = OP_ID;
                    2'd2:    trig_op = OP_STAT;
                    default: trig_ok = 1'b0;
                endcase
            end
            default: trig_ok = 1'b0;
        endcase
    end

    always_comb begin
        seq_d    = seq_q;
        tm_start = 1'b0;
        s_we     = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (wr_ok) begin
                    case (reg_addr)
                        RA_CMD: seq_d.cmd = reg_wdata;
                        RA_ADR: seq_d.adr = reg_wdata;
                        RA_CFG: begin
                            seq_d.wide   = reg_wdata[0];
                            seq_d.page2k = reg_wdata[1] & BIG_OK;
                            seq_d.tlen   = reg_wdata[7:4];
                        end
                        default: begin
                            if (trig_ok) begin
                                seq_d.op    = trig_op;
                                seq_d.idx   = '0;
                                seq_d.spare = 1'b0;
                                seq_d.done  = 1'b0;
                                if (op_reads(trig_op)) begin
                                    seq_d.st = ST_RDY;
                                end else begin
                                    seq_d.st = ST_XFER;
                                    tm_start = 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end
            ST_RDY: begin
                if (nand_rb_n) begin
                    seq_d.st = ST_XFER;
                    tm_start = 1'b1;
                end
            end
            ST_XFER: begin
                s_we = tm_sample && op_reads(seq_q.op);
                if (tm_last) begin
                    if (seq_q.idx == cur_len - CW'(1)) begin
                        if (!seq_q.spare && (seq_q.op == OP_DIN || seq_q.op == OP_PAGE)) begin
                            seq_d.spare = 1'b1;
                            seq_d.idx   = '0;
                            tm_start    = 1'b1;
                        end else begin
                            seq_d.st   = ST_IDLE;
                            seq_d.done = 1'b1;
                        end
                    end else begin
                        seq_d.idx = seq_q.idx + CW'(1);
                        tm_start  = 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, op: OP_CMD, spare: 1'b0, idx: '0, done: 1'b1,
                       cmd: '0, adr: '0, wide: 1'b0, page2k: 1'b0, tlen: TW'(2)};
        end else begin
            seq_q <= seq_d;
        end
    end

    nand_seq_pulse #(.TW(TW)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tm_start),
        .len    (tlen_eff),
        .low    (tm_low),
        .sample (tm_sample),
        .last   (tm_last)
    );

    nand_seq_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk     (clk),
        .h_we    (buf_we),
        .h_addr  (buf_addr),
        .h_wdata (buf_wdata),
        .h_rdata (buf_rdata),
        .s_we    (s_we),
        .s_mask  (s_mask),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .s_rdata (s_rdata)
    );

    // pins
    assign nand_ce_n  = idle;
    assign nand_cle   = (seq_q.st == ST_XFER) && (seq_q.op == OP_CMD);
    assign nand_ale   = (seq_q.st == ST_XFER) && (seq_q.op == OP_ADR);
    assign nand_dq_oe = (seq_q.st == ST_XFER) && op_drives(seq_q.op);
    assign nand_we_n  = !(tm_low && op_drives(seq_q.op));
    assign nand_re_n  = !(tm_low && op_reads(seq_q.op));

    always_comb begin
        case (seq_q.op)
            OP_CMD:  nand_dq_o = seq_q.cmd;
            OP_ADR:  nand_dq_o = seq_q.adr;
            OP_DIN:  nand_dq_o = seq_q.wide ? s_rdata
                               : {8'h00, (lane ? s_rdata[15:8] : s_rdata[7:0])};
            default: nand_dq_o = '0;
        endcase
    end

    always_comb begin
        case (reg_addr)
            RA_CMD:  reg_rdata = seq_q.cmd;
            RA_ADR:  reg_rdata = seq_q.adr;
            RA_CTL:  reg_rdata = {seq_q.done, 11'b0, ecc_status};
            default: reg_rdata = {8'h00, seq_q.tlen, 2'b00, seq_q.page2k, seq_q.wide};
        endcase
    end
endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic ce_n,
    input logic dq_oe,
    input logic done
);
    // R1, R2: a write cycle is never both command and address
    a_r1_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R3: strobes only while the chip is selected
    a_r3_strobe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    // R3: done stays low while the chip is selected
    a_r3_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !done);

    // R3: done rises together with chip deselect
    a_r3_done_rise_ce_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ce_n);

    // R7: no bus drive while reading
    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

    // R9: low pulses last at least two cycles
    a_r9_we_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !we_n);

    a_r9_re_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |=> !re_n);

    // R9: WE# and RE# never low together
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
endmodule

bind nand_op_seq nand_op_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cle   (nand_cle),
    .ale   (nand_ale),
    .we_n  (nand_we_n),
    .re_n  (nand_re_n),
    .ce_n  (nand_ce_n),
    .dq_oe (nand_dq_oe),
    .done  (seq_q.done)
);

// File: tb/test_nand_op_seq.sv
`timescale 1ns/1ps
module test_nand_op_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        buf_we = 1'b0;
    logic [9:0]  buf_addr = '0;
    logic [15:0] buf_wdata = '0;
    logic [15:0] buf_rdata;
    logic [3:0]  ecc_status = '0;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic        nand_rb_n = 1'b1;
    logic [15:0] nand_dq_o;
    logic        nand_dq_oe;
    logic [15:0] nand_dq_i = '0;

    always #2 clk = ~clk;

    nand_op_seq i_nand_op_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .ecc_status(ecc_status), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_rb_n(nand_rb_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // device model: logs write cycles, answers read cycles
    logic        w_cle [4096];
    logic        w_ale [4096];
    logic [15:0] w_dq  [4096];
    int wcnt = 0, rcnt = 0, low_run = 0, last_low = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    function automatic logic [15:0] pat(int n);
        return 16'((n * 259 + 4660) & 32'hFFFF);
    endfunction

    function automatic logic [15:0] hwpat(int hw);
        return 16'((hw * 769) & 32'hFFFF) ^ 16'h5A5A;
    endfunction

    always @(negedge clk) begin
        if (!nand_we_n) low_run++;
        if (!prev_we && nand_we_n) begin
            w_cle[wcnt % 4096] = nand_cle;
            w_ale[wcnt % 4096] = nand_ale;
            w_dq[wcnt % 4096]  = nand_dq_o;
            wcnt++;
            last_low = low_run;
            low_run = 0;
        end
        if (prev_re && !nand_re_n) begin
            nand_dq_i = pat(rcnt);
            rcnt++;
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic bwr(input int a, input logic [15:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 10'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic brd(input int a, output logic [15:0] d);
        buf_addr = 10'(a);
        #1 d = buf_rdata;
    endtask

    task automatic wait_done();
        logic [15:0] v;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            rd(2'd2, v);
            if (v[15]) break;
        end
    endtask

    // command / address vectors: bit16 = address phase, bits 7:0 = value
    localparam logic [16:0] VEC [6] = '{17'h00070, 17'h10000, 17'h00090,
                                        17'h100A5, 17'h000FF, 17'h1003C};

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int base, rbase, errs, nc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(2'd2, v);
        chk("R3 reset done", 32'(v[15]), 1);
        chk("R3 reset ce_n", 32'(nand_ce_n), 1);
        chk("R9 reset strobes", {30'b0, nand_we_n, nand_re_n}, 3);
        rd(2'd3, v);
        chk("R10 reset cfg", 32'(v), 32'h0020);

        // table walk: command and address phases
        for (int i = 0; i < 6; i++) begin
            logic [16:0] e;
            e = VEC[i];
            base = wcnt;
            wr(e[16] ? 2'd1 : 2'd0, {8'h00, e[7:0]});
            wr(2'd2, e[16] ? 16'h0002 : 16'h0001);
            rd(2'd2, v);
            chk("R3 done cleared", 32'(v[15]), 0);
            wait_done();
            chk(e[16] ? "R2 cycle count" : "R1 cycle count", 32'(wcnt - base), 1);
            chk(e[16] ? "R2 latch flags" : "R1 latch flags",
                {30'b0, w_cle[base % 4096], w_ale[base % 4096]},
                e[16] ? 32'd1 : 32'd2);
            chk(e[16] ? "R2 bus value" : "R1 bus value", 32'(w_dq[base % 4096]), 32'(e[7:0]));
            chk("R9 low width default", 32'(last_low), 2);
        end

        // R9: programmed and clamped pulse width
        wr(2'd3, 16'h0050);
        wr(2'd2, 16'h0001);
        wait_done();
        chk("R9 low width 5", 32'(last_low), 5);
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'h0001);
        wait_done();
        chk("R9 low width clamp", 32'(last_low), 2);

        // R10: 2 KB page refused with a 1 KB buffer
        wr(2'd3, 16'h0022);
        rd(2'd3, v);
        chk("R10 page2k refused", 32'(v), 32'h0020);

        // R11: ECC status readback
        ecc_status = 4'b1001;
        @(negedge clk); rd(2'd2, v);
        chk("R11 ecc readback", 32'(v[3:0]), 9);
        ecc_status = 4'b0110;
        @(negedge clk); rd(2'd2, v);
        chk("R11 ecc readback", 32'(v[3:0]), 6);

        // R5: 8-bit data input, main then spare
        for (int h = 0; h < 528; h++) bwr(h, hwpat(h));
        base = wcnt;
        wr(2'd2, 16'h0004);
        wait_done();
        chk("R5 byte count", 32'(wcnt - base), 528);
        errs = 0;
        for (int k = 0; k < 528; k++) begin
            int hw;
            logic [15:0] hv;
            hw = (k < 512) ? (k >> 1) : (512 + ((k - 512) >> 1));
            hv = hwpat(hw);
            if (w_dq[(base + k) % 4096] !== {8'h00, (k[0] ? hv[15:8] : hv[7:0])}) errs++;
            if (w_cle[(base + k) % 4096] || w_ale[(base + k) % 4096]) errs++;
        end
        chk("R5 byte stream", 32'(errs), 0);

        // R6: 16-bit data input
        wr(2'd3, 16'h0021);
        base = wcnt;
        wr(2'd2, 16'h0004);
        wait_done();
        chk("R6 word count", 32'(wcnt - base), 264);
        errs = 0;
        for (int u = 0; u < 264; u++) begin
            int hw;
            hw = (u < 256) ? u : (u + 256);
            if (w_dq[(base + u) % 4096] !== hwpat(hw)) errs++;
        end
        chk("R6 word stream", 32'(errs), 0);
        wr(2'd3, 16'h0020);

        // R7: page read held off by R/B#
        nand_rb_n = 1'b0;
        rbase = rcnt;
        wr(2'd2, 16'h0008);
        repeat (20) @(negedge clk);
        chk("R7 no RE# while busy", 32'(nand_re_n), 1);
        chk("R7 no reads while busy", 32'(rcnt - rbase), 0);
        chk("R3 ce_n low while pending", 32'(nand_ce_n), 0);
        nand_rb_n = 1'b1;
        wait_done();
        chk("R7 read count", 32'(rcnt - rbase), 528);
        errs = 0;
        for (int h = 0; h < 264; h++) begin
            int k;
            logic [15:0] p0, p1;
            k = (h < 256) ? 2 * h : 512 + 2 * (h - 256);
            p0 = pat(rbase + k);
            p1 = pat(rbase + k + 1);
            brd((h < 256) ? h : h + 256, v);
            if (v !== {p1[7:0], p0[7:0]}) errs++;
        end
        chk("R7 buffer contents", 32'(errs), 0);

        // R8: ID read then status read
        for (int h = 0; h < 4; h++) bwr(h, 16'hFFFF);
        rbase = rcnt;
        wr(2'd2, 16'h0018);
        wait_done();
        chk("R8 ID read count", 32'(rcnt - rbase), 4);
        brd(0, v);
        chk("R8 ID bytes 0-1", 32'(v), 32'({pat(rbase + 1) & 16'hFF, 8'h00}) | 32'(pat(rbase) & 16'hFF));
        brd(1, v);
        chk("R8 ID bytes 2-3", 32'(v), 32'({pat(rbase + 3) & 16'hFF, 8'h00}) | 32'(pat(rbase + 2) & 16'hFF));
        brd(2, v);
        chk("R8 rest untouched", 32'(v), 32'hFFFF);
        rbase = rcnt;
        wr(2'd2, 16'h0028);
        wait_done();
        chk("R8 status read count", 32'(rcnt - rbase), 1);
        brd(0, v);
        chk("R8 status byte", 32'(v[7:0]), 32'(pat(rbase) & 16'hFF));

        // R4: malformed starts
        base = wcnt; rbase = rcnt;
        wr(2'd2, 16'h0003);
        rd(2'd2, v);
        chk("R4 two-bit start ignored", {30'b0, v[15], nand_ce_n}, 3);
        wr(2'd2, 16'h0038);
        rd(2'd2, v);
        chk("R4 type 3 ignored", {30'b0, v[15], nand_ce_n}, 3);
        wr(2'd2, 16'h0000);
        rd(2'd2, v);
        chk("R4 empty start ignored", 32'(v[15]), 1);
        chk("R4 no bus activity", 32'((wcnt - base) + (rcnt - rbase)), 0);

        // R4: start and config writes during a running phase
        base = wcnt;
        wr(2'd2, 16'h0004);
        repeat (10) @(negedge clk);
        wr(2'd2, 16'h0001);
        rd(2'd2, v);
        chk("R4 busy start keeps done low", 32'(v[15]), 0);
        wr(2'd3, 16'h0021);
        wait_done();
        chk("R4 busy start dropped", 32'(wcnt - base), 528);
        nc = 0;
        for (int k = 0; k < 528; k++) if (w_cle[(base + k) % 4096]) nc++;
        chk("R4 no CLE cycle", 32'(nc), 0);
        rd(2'd3, v);
        chk("R4 busy cfg dropped", 32'(v), 32'h0020);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule